// File: doc/BRIEF.md
# Dual-Slot Execution List Tracker

This block keeps the bookkeeping for one engine's two-entry hardware submission queue. Each of the two slots (index 0 and 1) holds a pair of context descriptors, element 0 and element 1. A descriptor has a context identifier, a context base address and a live bit. A command port accepts two kinds of command. A schedule-in delivers a new descriptor pair. A schedule-out reports that a context has finished.

The block tracks which slot is running, whether a second slot waits as pending, and which element of the running slot is the current context. It classifies each command as one of the following: first start, lite-restore with preemption, plain queueing, element switch, retirement, or promotion of the pending slot. From that it updates a 64-bit status word and sends typed event records, one at a time, to a downstream status-buffer writer over a valid/ready handshake. Commands that break the queue rules are flagged on `cmd_err` and change nothing.

The tracker has three states. TR_IDLE means no slot is running. TR_RUN means one slot is running. TR_FULL means one slot is running and one is pending. The transitions are:
- START: TR_IDLE to TR_RUN.
- PREEMPT: TR_RUN to TR_RUN.
- QUEUE: TR_RUN to TR_FULL.
- ESWITCH: no state change.
- RETIRE: TR_RUN to TR_IDLE.
- PROMOTE: TR_FULL to TR_RUN.
- REJECT: no change.

The event port has its own state machine:
- EV_IDLE: nothing to send.
- EV_HEAD: the first of a two-record burst is presented.
- EV_TAIL: the last or only record is presented.

Top module: `exl_tracker`

## Requirements
- R1: After synchronous reset the status word is all zero, `evt_valid` is 0 and `cmd_ready` is 1. Both slots are cleared and the write pointer selects slot 0.
- R2: Two descriptors name the same context only when both the identifier and the base address are equal. A schedule-out whose identifier matches the running context but whose base address differs is rejected.
- R3: A schedule-in with element 0 live, while nothing runs, performs START. The pair is stored in the slot selected by the write pointer, that slot runs with element 0 current, and one event is sent with flags bit 0 (idle-to-active) only, context ID 0 and irq 1.
- R4: A schedule-in while running with no pending slot performs PREEMPT when either of two cases holds. In the first case, running element 1 is live, equals the new element 0, and element 1 is the current context. In the second case, running element 1 is not live and running element 0 equals the new element 0. PREEMPT stores the pair in the other slot and makes it the running slot with element 0 current. It sends one event with flags bit 1 (preempted) and bit 5 (lite-restore), the new element 0 identifier, and irq 1.
- R5: Any other accepted schedule-in while running with no pending slot performs QUEUE. The pair is stored in the other slot, which becomes pending, queue-full is set, and no event is sent.
- R6: A schedule-in while a pending slot exists is rejected.
- R7: A schedule-out of the current context, while it is element 0 and element 1 is live, performs ESWITCH. Element 1 becomes current, and one event is sent with flags bit 4 (context-complete) and bit 2 (element-switch), the finished identifier, and irq 1.
- R8: A schedule-out of the current context when it is the last live element and no slot is pending performs RETIRE. Nothing runs afterwards. The current and write pointers keep their values. One event is sent with flags bit 4 and bit 3 (active-to-idle), the finished identifier, and irq 1.
- R9: The same schedule-out with a slot pending performs PROMOTE. The pending slot runs with element 0 current. Two events are sent in order: first flags bits 4 and 3 with the finished identifier and irq 0, then flags bit 0 with context ID 0 and irq 1.
- R10: The status word is laid out as follows:
  - bit 0 is the current pointer and bit 1 is the write pointer. While running, these equal the running slot index and its inverse.
  - bits 2 and 3 are the valid and active bits of slot 0, and bits 4 and 5 are the same for slot 1. Only the running slot's pair is set.
  - bit 6 is queue-full, equal to pending-present.
  - bits 32 and up hold the current context identifier, or 0 when nothing runs.
  - all other bits are 0.
  The word changes on the clock edge that accepts the command.
- R11: A schedule-out while nothing runs, or one that names a context other than the current one, is rejected.
- R12: An event record stays valid and unchanged until `evt_ready` is seen high. `cmd_ready` is low while any record is outstanding.
- R13: A schedule-in whose element 0 is not live is rejected.

A rejected command raises `cmd_err` combinationally in its accepting cycle and leaves the status word and the event port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (no event outstanding) |
| cmd_is_out | input | 1 | 1 = schedule-out, 0 = schedule-in |
| cmd_e0_cid | input | CID_W | Element 0 identifier; the finished context for a schedule-out |
| cmd_e0_base | input | BASE_W | Element 0 base address |
| cmd_e0_live | input | 1 | Element 0 live bit |
| cmd_e1_cid | input | CID_W | Element 1 identifier |
| cmd_e1_base | input | BASE_W | Element 1 base address |
| cmd_e1_live | input | 1 | Element 1 live bit |
| cmd_err | output | 1 | Accepted command rejected (same cycle) |
| stat_word | output | 64 | Status word |
| evt_valid | output | 1 | Event record present |
| evt_ready | input | 1 | Buffer writer takes the record |
| evt_flags | output | 6 | Event flags (bit positions per R3 to R9) |
| evt_cid | output | CID_W | Event context identifier |
| evt_irq | output | 1 | Record should raise the interrupt |

## Verification
A corrupted running index, current element or pending flag shows up in the status word on the cycle right after the accepting edge. The slot bits, the pointers or the context identifier are then wrong. A wrong element pointer can also hide until a later schedule-out, where it becomes a wrong event type or a spurious `cmd_err`. A stale slot entry is only exposed when a later PREEMPT comparison or context identifier reads it. For this reason the random stimulus draws identifiers from a small pool and keeps re-submitting the running contexts. A fault in the event port shows at once as a record that changes under backpressure, a missing second record after PROMOTE, or `cmd_ready` rising too early.

// File: rtl/exl_pkg.sv
package exl_pkg;
    parameter int unsigned CID_W  = 16;
    parameter int unsigned BASE_W = 20;
    parameter int unsigned STAT_W = 64;
    parameter int unsigned EVF_W  = 6;
    parameter int unsigned NSLOT  = 2;
    localparam int unsigned IDX_W = $clog2(NSLOT);

    // event flag bit positions (decoded by the buffer writer)
    localparam int unsigned F_I2A     = 0;
    localparam int unsigned F_PREEMPT = 1;
    localparam int unsigned F_ESW     = 2;
    localparam int unsigned F_A2I     = 3;
    localparam int unsigned F_CC      = 4;
    localparam int unsigned F_LITE    = 5;

    // status word bit positions
    localparam int unsigned ST_CUR    = 0;
    localparam int unsigned ST_WR     = 1;
    localparam int unsigned ST_SLOT0  = 2;   // valid at ST_SLOT0+2g, active at +1
    localparam int unsigned ST_QF     = ST_SLOT0 + 2 * NSLOT;
    localparam int unsigned ST_CID    = 32;

    typedef struct packed {
        logic              live;
        logic [BASE_W-1:0] base;
        logic [CID_W-1:0]  cid;
    } desc_t;

    typedef struct packed {
        logic [EVF_W-1:0] flags;
        logic [CID_W-1:0] cid;
        logic             irq;
    } evt_t;

    typedef enum logic [1:0] {
        TR_IDLE = 2'd0,
        TR_RUN  = 2'd1,
        TR_FULL = 2'd2
    } trk_state_e;

    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_HEAD = 2'd1,
        EV_TAIL = 2'd2
    } ev_state_e;

    function automatic logic same_ctx(input desc_t a, input desc_t b);
        return (a.cid == b.cid) && (a.base == b.base);
    endfunction
endpackage

// File: rtl/exl_slot_bank.sv
module exl_slot_bank
    import exl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  desc_t                 wr_e0,
    input  desc_t                 wr_e1,
    output desc_t [NSLOT-1:0]     rd_e0,
    output desc_t [NSLOT-1:0]     rd_e1
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        desc_t e0_q, e1_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                e0_q <= '0;
                e1_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                e0_q <= wr_e0;
                e1_q <= wr_e1;
            end
        end

        assign rd_e0[g] = e0_q;
        assign rd_e1[g] = e1_q;
    end
endmodule

// File: rtl/exl_status_fmt.sv
module exl_status_fmt
    import exl_pkg::*;
(
    input  logic               running,
    input  logic               pend,
    input  logic               cur_ptr,
    input  logic               wr_ptr,
    input  logic [IDX_W-1:0]   run_idx,
    input  logic [CID_W-1:0]   run_cid,
    output logic [STAT_W-1:0]  word
);
    always_comb begin
        word          = '0;
        word[ST_CUR]  = cur_ptr;
        word[ST_WR]   = wr_ptr;
        for (int g = 0; g < NSLOT; g++) begin
            word[ST_SLOT0 + 2 * g]     = running && (run_idx == IDX_W'(g));
            word[ST_SLOT0 + 2 * g + 1] = running && (run_idx == IDX_W'(g));
        end
        word[ST_QF]   = pend;
        word[ST_CID +: CID_W] = running ? run_cid : '0;
    end
endmodule

// File: rtl/exl_evt_port.sv
module exl_evt_port
    import exl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  two,
    input  evt_t  rec_in,
    output logic  busy,
    output logic  evt_valid,
    input  logic  evt_ready,
    output evt_t  rec_out
);
    ev_state_e st_q, st_d;
    evt_t      rec_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= EV_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EV_IDLE: if (load)      st_d = two ? EV_HEAD : EV_TAIL;
            EV_HEAD: if (evt_ready) st_d = EV_TAIL;
            EV_TAIL: if (evt_ready) st_d = EV_IDLE;
            default:                st_d = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (st_q == EV_IDLE && load) begin
            rec_q <= rec_in;
        end else if (st_q == EV_HEAD && evt_ready) begin
            rec_q              <= '0;
            rec_q.flags[F_I2A] <= 1'b1;
            rec_q.irq          <= 1'b1;
        end
    end

    assign evt_valid = (st_q != EV_IDLE);
    assign busy      = evt_valid;
    assign rec_out   = rec_q;

    // R12: a record under backpressure stays put
    assert_evt_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(rec_q)));

    // R9: the head of a burst is always followed by an idle-to-active record
    assert_burst_tail_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == EV_HEAD && evt_ready) |=> (evt_valid && rec_q.flags[F_I2A] && rec_q.irq));
endmodule

// File: rtl/exl_tracker.sv
module exl_tracker
    import exl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic                cmd_is_out,
    input  logic [CID_W-1:0]    cmd_e0_cid,
    input  logic [BASE_W-1:0]   cmd_e0_base,
    input  logic                cmd_e0_live,
    input  logic [CID_W-1:0]    cmd_e1_cid,
    input  logic [BASE_W-1:0]   cmd_e1_base,
    input  logic                cmd_e1_live,
    output logic                cmd_err,
    output logic [STAT_W-1:0]   stat_word,
    output logic                evt_valid,
    input  logic                evt_ready,
    output logic [EVF_W-1:0]    evt_flags,
    output logic [CID_W-1:0]    evt_cid,
    output logic                evt_irq
);
    trk_state_e        st_q, st_d;
    logic [IDX_W-1:0]  run_idx_q, run_idx_d;
    logic              elem_q, elem_d;
    logic              cur_q, cur_d;
    logic              wr_q, wr_d;

    desc_t             in0, in1;
    desc_t [NSLOT-1:0] bank_e0, bank_e1;
    desc_t             run0, run1, run_ctx;
    logic              bank_we;
    logic              ev_load, ev_two, ev_busy;
    evt_t              ev_rec, ev_out;
    logic              fire, hit, err;

    assign in0 = '{live: cmd_e0_live, base: cmd_e0_base, cid: cmd_e0_cid};
    assign in1 = '{live: cmd_e1_live, base: cmd_e1_base, cid: cmd_e1_cid};

    exl_slot_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bank_we),
        .wr_idx (wr_q),
        .wr_e0  (in0),
        .wr_e1  (in1),
        .rd_e0  (bank_e0),
        .rd_e1  (bank_e1)
    );

    assign run0    = bank_e0[run_idx_q];
    assign run1    = bank_e1[run_idx_q];
    assign run_ctx = elem_q ? run1 : run0;

    assign cmd_ready = !ev_busy;
    assign fire      = cmd_valid && cmd_ready;

    // lite-restore detection against the running slot
    assign hit = (run1.live && elem_q && same_ctx(run1, in0)) ||
                 (!run1.live && same_ctx(run0, in0));

    // tracker state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= TR_IDLE;
            run_idx_q <= '0;
            elem_q    <= 1'b0;
            cur_q     <= 1'b0;
            wr_q      <= 1'b0;
        end else begin
            st_q      <= st_d;
            run_idx_q <= run_idx_d;
            elem_q    <= elem_d;
            cur_q     <= cur_d;
            wr_q      <= wr_d;
        end
    end

    // transition and output decode
    always_comb begin
        st_d      = st_q;
        run_idx_d = run_idx_q;
        elem_d    = elem_q;
        cur_d     = cur_q;
        wr_d      = wr_q;
        bank_we   = 1'b0;
        ev_load   = 1'b0;
        ev_two    = 1'b0;
        ev_rec    = '0;
        err       = 1'b0;
        if (fire) begin
            if (!cmd_is_out) begin
                if (!in0.live) begin
                    err = 1'b1;                       // REJECT
                end else begin
                    unique case (st_q)
                        TR_IDLE: begin                // START
                            bank_we   = 1'b1;
                            st_d      = TR_RUN;
                            run_idx_d = wr_q;
                            elem_d    = 1'b0;
                            cur_d     = wr_q;
                            wr_d      = !wr_q;
                            ev_load   = 1'b1;
                            ev_rec.flags[F_I2A] = 1'b1;
                            ev_rec.irq = 1'b1;
                        end
                        TR_RUN: begin
                            bank_we = 1'b1;
                            if (hit) begin            // PREEMPT
                                run_idx_d = wr_q;
                                elem_d    = 1'b0;
                                cur_d     = wr_q;
                                wr_d      = !wr_q;
                                ev_load   = 1'b1;
                                ev_rec.flags[F_LITE]    = 1'b1;
                                ev_rec.flags[F_PREEMPT] = 1'b1;
                                ev_rec.cid = in0.cid;
                                ev_rec.irq = 1'b1;
                            end else begin            // QUEUE
                                st_d = TR_FULL;
                            end
                        end
                        default: err = 1'b1;          // REJECT (full)
                    endcase
                end
            end else begin
                if (st_q == TR_IDLE || !same_ctx(in0, run_ctx)) begin
                    err = 1'b1;                       // REJECT
                end else if (!elem_q && run1.live) begin   // ESWITCH
                    elem_d  = 1'b1;
                    ev_load = 1'b1;
                    ev_rec.flags[F_CC]  = 1'b1;
                    ev_rec.flags[F_ESW] = 1'b1;
                    ev_rec.cid = in0.cid;
                    ev_rec.irq = 1'b1;
                end else if (st_q == TR_FULL) begin  // PROMOTE
                    st_d      = TR_RUN;
                    run_idx_d = wr_q;
                    elem_d    = 1'b0;
                    cur_d     = wr_q;
                    wr_d      = !wr_q;
                    ev_load   = 1'b1;
                    ev_two    = 1'b1;
                    ev_rec.flags[F_CC]  = 1'b1;
                    ev_rec.flags[F_A2I] = 1'b1;
                    ev_rec.cid = in0.cid;
                    ev_rec.irq = 1'b0;
                end else begin                        // RETIRE
                    st_d    = TR_IDLE;
                    elem_d  = 1'b0;
                    ev_load = 1'b1;
                    ev_rec.flags[F_CC]  = 1'b1;
                    ev_rec.flags[F_A2I] = 1'b1;
                    ev_rec.cid = in0.cid;
                    ev_rec.irq = 1'b1;
                end
            end
        end
    end

    assign cmd_err = err;

    exl_evt_port u_evt (
        .clk       (clk),
        .rst       (rst),
        .load      (ev_load),
        .two       (ev_two),
        .rec_in    (ev_rec),
        .busy      (ev_busy),
        .evt_valid (evt_valid),
        .evt_ready (evt_ready),
        .rec_out   (ev_out)
    );

    assign evt_flags = ev_out.flags;
    assign evt_cid   = ev_out.cid;
    assign evt_irq   = ev_out.irq;

    exl_status_fmt u_stat (
        .running (st_q != TR_IDLE),
        .pend    (st_q == TR_FULL),
        .cur_ptr (cur_q),
        .wr_ptr  (wr_q),
        .run_idx (run_idx_q),
        .run_cid (run_ctx.cid),
        .word    (stat_word)
    );

    // R6 and R11: a rejected command leaves the status word alone
    assert_reject_keeps_status_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_err) |=> $stable(stat_word));

    // R10: pointers follow the running slot
    assert_ptrs_follow_run_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q != TR_IDLE) |-> (stat_word[ST_CUR] == run_idx_q && stat_word[ST_WR] != stat_word[ST_CUR]));

    // R5: queue-full only alongside a running slot
    assert_qfull_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
        stat_word[ST_QF] |-> $onehot(stat_word[ST_SLOT0 +: 2 * NSLOT] & {NSLOT{2'b01}}));

    // R12: no command accepted while a record is outstanding
    assert_busy_blocks_cmd_R12: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> !cmd_ready);

    // R3: START is followed by an idle-to-active record
    assert_start_event_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && !cmd_is_out && cmd_e0_live && st_q == TR_IDLE)
        |=> (evt_valid && evt_flags[F_I2A] && evt_irq && evt_cid == '0));
endmodule

// File: tb/exl_tracker_test.sv
module exl_tracker_test;
    import exl_pkg::*;

    localparam int CLK_P = 10;
    localparam int RW    = EVF_W + CID_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_is_out = 1'b0;
    logic [CID_W-1:0]  e0_cid = '0, e1_cid = '0;
    logic [BASE_W-1:0] e0_base = '0, e1_base = '0;
    logic e0_live = 1'b0, e1_live = 1'b0;
    logic evt_ready = 1'b0;
    logic cmd_ready, cmd_err, evt_valid, evt_irq;
    logic [STAT_W-1:0] stat_word;
    logic [EVF_W-1:0]  evt_flags;
    logic [CID_W-1:0]  evt_cid;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    exl_tracker uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_is_out(cmd_is_out),
        .cmd_e0_cid(e0_cid), .cmd_e0_base(e0_base), .cmd_e0_live(e0_live),
        .cmd_e1_cid(e1_cid), .cmd_e1_base(e1_base), .cmd_e1_live(e1_live),
        .cmd_err(cmd_err), .stat_word(stat_word),
        .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_flags(evt_flags), .evt_cid(evt_cid), .evt_irq(evt_irq)
    );

    // reference model state
    bit m_run, m_pend, m_idx, m_elem, m_cur, m_wr;
    logic [CID_W-1:0]  m_c0 [2], m_c1 [2];
    logic [BASE_W-1:0] m_b0 [2], m_b1 [2];
    bit                m_l0 [2], m_l1 [2];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] rec(input int fl, input logic [CID_W-1:0] c, input bit irq);
        return {EVF_W'(fl), c, irq};
    endfunction

    function automatic logic [STAT_W-1:0] exp_status();
        logic [STAT_W-1:0] w = '0;
        w[0] = m_cur;
        w[1] = m_wr;
        if (m_run) begin
            w[2 + 2*m_idx] = 1'b1;
            w[3 + 2*m_idx] = 1'b1;
            w[32 +: CID_W] = m_elem ? m_c1[m_idx] : m_c0[m_idx];
        end
        w[6] = m_pend;
        return w;
    endfunction

    task automatic model(input bit is_out,
                         input logic [CID_W-1:0] c0, input logic [BASE_W-1:0] b0, input bit l0,
                         input logic [CID_W-1:0] c1, input logic [BASE_W-1:0] b1, input bit l1,
                         output bit err, output int n, output logic [RW-1:0] ra,
                         output logic [RW-1:0] rb, output string tag);
        err = 1'b0; n = 0; ra = '0; rb = '0; tag = "";
        if (!is_out) begin
            if (!l0) begin
                err = 1'b1; tag = "R13";
            end else if (!m_run) begin
                m_c0[m_wr] = c0; m_b0[m_wr] = b0; m_l0[m_wr] = l0;
                m_c1[m_wr] = c1; m_b1[m_wr] = b1; m_l1[m_wr] = l1;
                m_run = 1; m_idx = m_wr; m_elem = 0; m_cur = m_wr; m_wr = !m_wr;
                n = 1; ra = rec(1, '0, 1); tag = "R3";
            end else if (m_pend) begin
                err = 1'b1; tag = "R6";
            end else begin
                bit h;
                h = (m_l1[m_idx] && m_elem && m_c1[m_idx] == c0 && m_b1[m_idx] == b0) ||
                    (!m_l1[m_idx] && m_c0[m_idx] == c0 && m_b0[m_idx] == b0);
                m_c0[m_wr] = c0; m_b0[m_wr] = b0; m_l0[m_wr] = l0;
                m_c1[m_wr] = c1; m_b1[m_wr] = b1; m_l1[m_wr] = l1;
                if (h) begin
                    m_idx = m_wr; m_elem = 0; m_cur = m_wr; m_wr = !m_wr;
                    n = 1; ra = rec(6'b100010, c0, 1); tag = "R4";
                end else begin
                    m_pend = 1; tag = "R5";
                end
            end
        end else begin
            logic [CID_W-1:0] rc; logic [BASE_W-1:0] rbase;
            rc    = m_elem ? m_c1[m_idx] : m_c0[m_idx];
            rbase = m_elem ? m_b1[m_idx] : m_b0[m_idx];
            if (!m_run || rc != c0 || rbase != b0) begin
                err = 1'b1;
                tag = (m_run && rc == c0) ? "R2" : "R11";
            end else if (!m_elem && m_l1[m_idx]) begin
                m_elem = 1; n = 1; ra = rec(6'b010100, c0, 1); tag = "R7";
            end else if (m_pend) begin
                m_idx = m_wr; m_elem = 0; m_cur = m_wr; m_wr = !m_wr; m_pend = 0;
                n = 2; ra = rec(6'b011000, c0, 0); rb = rec(1, '0, 1); tag = "R9";
            end else begin
                m_run = 0; m_elem = 0;
                n = 1; ra = rec(6'b011000, c0, 1); tag = "R8";
            end
        end
    endtask

    task automatic run_cmd(input bit is_out,
                           input logic [CID_W-1:0] c0, input logic [BASE_W-1:0] b0, input bit l0,
                           input logic [CID_W-1:0] c1, input logic [BASE_W-1:0] b1, input bit l1);
        bit xerr; int n; logic [RW-1:0] ra, rb, r; string tag;
        model(is_out, c0, b0, l0, c1, b1, l1, xerr, n, ra, rb, tag);
        @(negedge clk);
        check("R12 ready before command", 64'(cmd_ready), 64'(1));
        cmd_is_out = is_out;
        e0_cid = c0; e0_base = b0; e0_live = l0;
        e1_cid = c1; e1_base = b1; e1_live = l1;
        cmd_valid = 1'b1;
        #1;
        check({tag, " cmd_err"}, 64'(cmd_err), 64'(xerr));
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 status", stat_word, exp_status());
        check({tag, " evt_valid"}, 64'(evt_valid), 64'(n > 0));
        for (int k = 0; k < n; k++) begin
            r = (k == 0) ? ra : rb;
            for (int w = 0; w < int'($urandom % 3); w++) begin
                check("R12 hold", 64'({evt_valid, evt_flags, evt_cid, evt_irq}), 64'({1'b1, r}));
                check("R12 ready low", 64'(cmd_ready), 64'(0));
                @(negedge clk);
            end
            evt_ready = 1'b1;
            check({tag, " record"}, 64'({evt_valid, evt_flags, evt_cid, evt_irq}), 64'({1'b1, r}));
            @(negedge clk);
            evt_ready = 1'b0;
        end
        check({tag, " drained"}, 64'(evt_valid), 64'(0));
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7125));
        m_run = 0; m_pend = 0; m_idx = 0; m_elem = 0; m_cur = 0; m_wr = 0;
        for (int s = 0; s < 2; s++) begin
            m_c0[s] = '0; m_c1[s] = '0; m_b0[s] = '0; m_b1[s] = '0; m_l0[s] = 0; m_l1[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status", stat_word, '0);
        check("R1 evt_valid", 64'(evt_valid), 64'(0));
        check("R1 cmd_ready", 64'(cmd_ready), 64'(1));

        // directed corner cases
        run_cmd(1, 16'h1, 20'h10, 1, 16'h0, 20'h0, 0);   // R11 idle schedule-out
        run_cmd(0, 16'h1, 20'h10, 1, 16'h0, 20'h0, 0);   // R3 start
        run_cmd(0, 16'h1, 20'h10, 1, 16'h0, 20'h0, 0);   // R4 second case
        run_cmd(0, 16'h2, 20'h20, 1, 16'h3, 20'h30, 1);  // R5 queue
        run_cmd(0, 16'h4, 20'h40, 1, 16'h0, 20'h0, 0);   // R6 full
        run_cmd(1, 16'h1, 20'h11, 1, 16'h0, 20'h0, 0);   // R2 base mismatch
        run_cmd(1, 16'h1, 20'h10, 1, 16'h0, 20'h0, 0);   // R9 promote
        run_cmd(1, 16'h2, 20'h20, 1, 16'h0, 20'h0, 0);   // R7 element switch
        run_cmd(0, 16'h3, 20'h30, 1, 16'h5, 20'h50, 1);  // R4 first case
        run_cmd(1, 16'h3, 20'h30, 1, 16'h0, 20'h0, 0);   // R7
        run_cmd(1, 16'h5, 20'h50, 1, 16'h0, 20'h0, 0);   // R8 retire
        run_cmd(0, 16'h6, 20'h60, 0, 16'h0, 20'h0, 0);   // R13 dead element 0

        // constrained random
        for (int i = 0; i < 600; i++) begin
            bit out_op;
            logic [CID_W-1:0] c0, c1;
            logic [BASE_W-1:0] b0, b1;
            bit l0, l1;
            out_op = ($urandom % 2) == 1;
            c0 = CID_W'(1 + $urandom % 3);  b0 = BASE_W'(16 * (1 + $urandom % 2));
            c1 = CID_W'(1 + $urandom % 3);  b1 = BASE_W'(16 * (1 + $urandom % 2));
            l0 = ($urandom % 16) != 0;      l1 = ($urandom % 2) == 1;
            if (m_run && ($urandom % 8) != 0) begin
                if (out_op) begin
                    c0 = m_elem ? m_c1[m_idx] : m_c0[m_idx];
                    b0 = m_elem ? m_b1[m_idx] : m_b0[m_idx];
                end else if (($urandom % 2) == 1) begin
                    c0 = m_l1[m_idx] ? m_c1[m_idx] : m_c0[m_idx];
                    b0 = m_l1[m_idx] ? m_b1[m_idx] : m_b0[m_idx];
                end
            end
            run_cmd(out_op, c0, b0, l0, c1, b1, l1);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule